// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream. It holds a chain of `N` stages, eight by default. An active-low load input copies the parallel inputs into every stage. That load is level-sensitive: while it stays low, the stages keep following the parallel bus, and the clock inputs and the serial input have no effect. When load is high, a rising edge of the effective shift clock moves every stage one place toward the last stage, and the first stage takes the serial input. The block drives the last stage and its complement.

The effective shift clock is the OR of two inputs that can swap roles. If one of them is held high, the other cannot produce a rising edge, so either input works as an active-low clock enable. All four control inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and a shift fires on the system cycle where the synchronised OR goes from 0 to 1. A chain longer than `N` is built by connecting the last-stage output of one block to the serial input of the next.

Top module: `piso_shift_reg`

## Requirements
- R1: While the synchronous reset is high, and on the cycle after it, every stage holds 0. `q_last` reads 0 and `q_last_n` reads 1.
- R2: While `load_n` (synchronised) is low, stage i takes `d[i]` on every system clock edge. A change on `d` while load is held shows on `q_last` (which carries `d[N-1]`) one system cycle later.
- R3: While `load_n` is low, toggling `cp`, `ce` or `ds` leaves `q_last` equal to `d[N-1]`.
- R4: With `load_n` high, each 0-to-1 change of `cp | ce` shifts stage i into stage i+1 and puts `ds` into stage 0. After a load, the serial readout is `d[N-1]` first, then `d[N-2]`, and so on. The `ds` values follow in the order they were shifted in.
- R5: While `ce` is held high, pulses on `cp` leave the stages unchanged. With `cp` held low, a rising edge on `ce` shifts, just as a rising edge on `cp` does.
- R6: A rising edge on `ce` while `cp` is high causes no shift, and neither does its later fall.
- R7: When `load_n` rises while `cp` or `ce` is high, no shift happens. No shift ever fires on the system cycle in which the synchronised load is released.
- R8: `q_last_n` is always the inverse of `q_last`.
- R9: A change at a control input reaches `q_last` on the third system clock edge after it is driven: two synchroniser edges, then the stage update.
- R10: Two blocks cascaded through `q_last` into `ds` deliver all 2N loaded bits on the far `q_last`. The far block's word comes out first, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load, active low, asynchronous to clk |
| cp | input | 1 | Shift clock input A, ORed with `ce` |
| ce | input | 1 | Shift clock input B, ORed with `cp` (acts as active-low enable) |
| ds | input | 1 | Serial data into stage 0 |
| d | input | N | Parallel data, bit i goes to stage i |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
Load release and a shift-clock edge can fall on the same synchronised cycle. A rising edge of the clock OR also competes with the enable input that blocks it. The bench provokes the first case by releasing load while `cp`, or separately `ce`, is already high. It provokes the second by raising `ce` while `cp` is high. In each case `q_last` must keep `d[N-1]`, and a clean `cp` pulse afterwards must move the next bit out. The cascade test then checks that a shift fired by one shared edge in both blocks carries the near block's last stage into the far block without losing or doubling a bit.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Synchronised control inputs, carried as one word through the synchroniser
    typedef struct packed {
        logic load_n;
        logic cp;
        logic ce;
        logic ds;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Reset state: load idle, both clock inputs treated as high (no edge armed)
    localparam ctl_t CTL_IDLE = '{load_n: 1'b1, cp: 1'b1, ce: 1'b1, ds: 1'b0};

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } op_e;

    // Load wins; a shift needs load high now and last cycle plus a fresh OR edge
    function automatic op_e pick_op(input logic ld_n_now, input logic ld_n_prev,
                                    input logic or_now,   input logic or_prev);
        if (!ld_n_now)
            return OP_LOAD;
        else if (ld_n_prev && or_now && !or_prev)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] ff;
            always_ff @(posedge clk) begin
                if (rst) ff <= RST_VAL;
                else     ff <= din;
            end
            assign dout = ff;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] ff;
            always_ff @(posedge clk) begin
                if (rst) ff <= {STAGES{RST_VAL}};
                else     ff <= {ff[STAGES-2:0], din};
            end
            assign dout = ff[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic s_load_n,
    input  logic s_cp,
    input  logic s_ce,
    output op_e  op
);

    logic clk_or;
    logic or_q;
    logic load_q;

    assign clk_or = s_cp | s_ce;

    // Edge history is refreshed every cycle, so it is re-armed on release
    always_ff @(posedge clk) begin
        if (rst) begin
            or_q   <= 1'b1;
            load_q <= 1'b1;
        end else begin
            or_q   <= clk_or;
            load_q <= s_load_n;
        end
    end

    assign op = pick_op(s_load_n, load_q, clk_or, or_q);

endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  op_e          op,
    input  logic         ser_in,
    input  logic [N-1:0] par_in,
    output logic [N-1:0] stages
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else begin
            case (op)
                OP_LOAD:  stages <= par_in;
                OP_SHIFT: stages <= {stages[N-2:0], ser_in};
                default:  stages <= stages;
            endcase
        end
    end

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int N         = 8,
    parameter int SYNC_LEN  = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         cp,
    input  logic         ce,
    input  logic         ds,
    input  logic [N-1:0] d,
    output logic         q_last,
    output logic         q_last_n
);

    ctl_t         raw_ctl;
    ctl_t         s_ctl;
    logic         s_load_n;
    logic         s_cp;
    logic         s_ce;
    logic         s_ds;
    op_e          op;
    logic [N-1:0] stages;

    assign raw_ctl = '{load_n: load_n, cp: cp, ce: ce, ds: ds};

    piso_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_LEN),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_ctl),
        .dout (s_ctl)
    );

    assign s_load_n = s_ctl.load_n;
    assign s_cp     = s_ctl.cp;
    assign s_ce     = s_ctl.ce;
    assign s_ds     = s_ctl.ds;

    piso_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .s_load_n (s_load_n),
        .s_cp     (s_cp),
        .s_ce     (s_ce),
        .op       (op)
    );

    piso_stages #(.N(N)) u_stages (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ser_in (s_ds),
        .par_in (d),
        .stages (stages)
    );

    assign q_last   = stages[N-1];
    assign q_last_n = ~stages[N-1];

endmodule

// File: rtl/piso_shift_reg_chk.sv
module piso_shift_reg_chk
    import piso_pkg::*;
#(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] d,
    input logic         s_load_n,
    input logic         s_cp,
    input logic         s_ce,
    input logic         s_ds,
    input op_e          op,
    input logic [N-1:0] stages,
    input logic         q_last,
    input logic         q_last_n
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q === 1'b1)
            AST_RESET_CLEAR: assert (q_last == 1'b0 && q_last_n == 1'b1); // R1
    end

    AST_LOAD_TRACK: assert property (@(posedge clk) disable iff (rst)
        !s_load_n |=> stages == $past(d)); // R2

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        op == OP_SHIFT |=> stages == {$past(stages[N-2:0]), $past(s_ds)}); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (s_load_n && op != OP_SHIFT) |=> $stable(stages)); // R5

    AST_GATED_EDGE: assert property (@(posedge clk) disable iff (rst)
        op == OP_SHIFT |-> $past(!s_cp && !s_ce)); // R6

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (s_load_n && !$past(s_load_n)) |-> op != OP_SHIFT); // R7

endmodule

bind piso_shift_reg piso_shift_reg_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .d        (d),
    .s_load_n (s_load_n),
    .s_cp     (s_cp),
    .s_ce     (s_ce),
    .s_ds     (s_ds),
    .op       (op),
    .stages   (stages),
    .q_last   (q_last),
    .q_last_n (q_last_n)
);

// File: tb/piso_shift_reg_bench.sv
`timescale 1ns/1ps
module piso_shift_reg_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         cp = 1'b0;
    logic         ce = 1'b0;
    logic         ds = 1'b0;
    logic [N-1:0] d = '0;
    logic [N-1:0] d_far = '0;
    logic         q_a, q_a_n, q_b, q_b_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    piso_shift_reg #(.N(N)) u_piso_shift_reg (
        .clk(clk), .rst(rst), .load_n(load_n), .cp(cp), .ce(ce), .ds(ds),
        .d(d), .q_last(q_a), .q_last_n(q_a_n)
    );

    piso_shift_reg #(.N(N)) u_piso_shift_reg_far (
        .clk(clk), .rst(rst), .load_n(load_n), .cp(cp), .ce(ce), .ds(q_a),
        .d(d_far), .q_last(q_b), .q_last_n(q_b_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0b exp=%0b", req, got, exp);
        end
    endtask

    task automatic chk_pair(input string req, input logic exp);
        chk(req, q_a, exp);
        chk("R8", q_a_n, ~exp);
    endtask

    task automatic load_word(input logic [N-1:0] val, input logic cpv, input logic cev);
        cp = cpv; ce = cev; d = val; load_n = 1'b0;
        tick(4);
        load_n = 1'b1;
        tick(4);
    endtask

    task automatic pulse_cp();
        cp = 1'b1; tick(4);
        cp = 1'b0; tick(4);
    endtask

    task automatic t_reset();
        tick(3);
        chk_pair("R1", 1'b0);
        rst = 1'b0;
        tick(1);
        chk_pair("R1", 1'b0);
    endtask

    task automatic t_load();
        d = 8'hA5; load_n = 1'b0;
        tick(2);
        chk_pair("R9", 1'b0);
        tick(1);
        chk_pair("R9", 1'b1);
        d = 8'h25;
        tick(1);
        chk_pair("R2", 1'b0);
    endtask

    task automatic t_override();
        d = 8'h80;
        tick(1);
        chk_pair("R2", 1'b1);
        for (int i = 0; i < 8; i++) begin
            cp = ~cp; ds = ~ds;
            if (i % 3 == 0) ce = ~ce;
            tick(1);
            chk_pair("R3", 1'b1);
        end
        cp = 1'b0; ce = 1'b0; ds = 1'b0;
        tick(4);
        load_n = 1'b1;
        tick(4);
        chk_pair("R3", 1'b1);
    endtask

    task automatic t_shift();
        logic [N-1:0] word = 8'hB2;
        logic [7:0]   pat  = 8'b1011_0110;
        load_word(word, 1'b0, 1'b0);
        for (int i = 0; i < N; i++) begin
            chk_pair("R4", word[N-1-i]);
            ds = pat[i];
            pulse_cp();
        end
        for (int i = 0; i < 4; i++) begin
            chk_pair("R4", pat[i]);
            ds = 1'b0;
            pulse_cp();
        end
    endtask

    task automatic t_enable();
        load_word(8'h55, 1'b0, 1'b1);
        chk_pair("R5", 1'b0);
        for (int i = 0; i < 3; i++) begin
            pulse_cp();
            chk_pair("R5", 1'b0);
        end
        ce = 1'b0; tick(4);
        chk_pair("R5", 1'b0);
        ce = 1'b1; tick(4);
        chk_pair("R5", 1'b1);
        ce = 1'b0; tick(4);
    endtask

    task automatic t_release_and_ce();
        load_word(8'h55, 1'b1, 1'b0);
        chk_pair("R7", 1'b0);
        ce = 1'b1; tick(4);
        chk_pair("R6", 1'b0);
        ce = 1'b0; tick(4);
        chk_pair("R6", 1'b0);
        cp = 1'b0; tick(4);
        pulse_cp();
        chk_pair("R4", 1'b1);
        load_word(8'h55, 1'b0, 1'b1);
        chk_pair("R7", 1'b0);
        ce = 1'b0; tick(4);
        chk_pair("R7", 1'b0);
    endtask

    task automatic t_chain();
        logic [N-1:0] near_w = 8'hC3;
        logic [N-1:0] far_w  = 8'h5A;
        logic         ref_q[$];
        for (int i = N - 1; i >= 0; i--) ref_q.push_back(far_w[i]);
        for (int i = N - 1; i >= 0; i--) ref_q.push_back(near_w[i]);
        ds = 1'b0;
        d_far = far_w;
        load_word(near_w, 1'b0, 1'b0);
        for (int i = 0; i < 2 * N; i++) begin
            logic e = ref_q.pop_front();
            chk("R10", q_b, e);
            chk("R8", q_b_n, ~e);
            pulse_cp();
        end
    endtask

    initial begin
        t_reset();
        t_load();
        t_override();
        t_shift();
        t_enable();
        t_release_and_ce();
        t_chain();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule